// File: doc/BRIEF.md
# BCD Calendar Counter with Selective Alarm

This block keeps a running calendar in packed BCD: seconds, minutes, hours, day of month, month, two-digit year, weekday and century. It moves forward by one second on each single-cycle pulse of a once-per-second tick, and it carries through minutes, hours, days, months, years and centuries. The length of each month and the leap-year February are handled.

A second bank of eight bytes holds an alarm setting with the same field layout. Seconds, minutes, hours, date and month each carry a compare-enable flag in bit 7, so an alarm can match on any subset of those fields, such as "every minute at :05" or "12:30 on the 1st". After each tick, the alarm is compared with the updated time. A match latches a sticky pending flag in a status register. An interrupt output follows that flag only while an enable bit in a control register is set. Software reads and writes every field through a byte-wide register port that decodes on a single clock.

Top module: `bcd_rtc_alarm`

## Requirements
- R1: After reset the time reads 00:00:00 with hour byte 0x80, date 0x01, month 0x01, year 0x00, weekday 0x00, century 0x20. All alarm bytes read 0x00. The pending flag, the interrupt enable and `irq_o` are all 0.
- R2: The register map is as follows. Time fields sit at 0x30..0x37 in the order seconds, minutes, hours, date, month, year, weekday, century, and the alarm bank uses the same order at 0x00..0x07. Bit 5 of 0x11 is the interrupt enable and bit 5 of 0x3F is the pending flag. Other bits of those two bytes, and all unmapped addresses, read 0. A write to the time weekday keeps only its low 3 bits. `rdata_o` follows `addr_i` in the same cycle.
- R3: On a tick, seconds advance in BCD. From 0x59 they wrap to 0x00 and add one minute, and minutes wrap from 0x59 to 0x00 in the same way and add one hour.
- R4: Hours (low 6 bits of the hour byte) wrap from 0x23 to 0x00 and advance both the date and the weekday, with the weekday wrapping from 6 to 0. Bit 7 of the hour byte (24-hour mode) is kept unchanged by counting.
- R5: The date wraps to 0x01 and advances the month after the last day of the month: 30 days for April, June, September and November, and 31 days for the other non-February months.
- R6: February has 29 days when the BCD year is a multiple of 4 (00 counts), and 28 days otherwise.
- R7: The month wraps from 0x12 to 0x01 and advances the year. The year wraps from 0x99 to 0x00 and advances the century in BCD.
- R8: When a register write and a tick land in the same cycle, the tick is applied to every field and the written field then takes the written value.
- R9: A match happens on a tick when every alarm field among the first five that has bit 7 set equals the updated time field. Hours compare on the low 6 bits and the other fields compare on the low 7 bits. A match sets the pending flag.
- R10: Alarm fields with bit 7 clear take no part in the match. With no enable bit set, no match occurs.
- R11: The pending flag stays set across later matches and ticks. A status write with bit 5 at 1 leaves it unchanged, a status write with bit 5 at 0 clears it, and a match in the same cycle as a clearing write keeps it set.
- R12: `irq_o` is the pending flag gated by the interrupt-enable bit, and `alarm_pending_o` mirrors the pending flag.
- R13: Without a tick or a write, the time bank holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| alarm_pending_o | output | 1 | Alarm pending flag |
| irq_o | output | 1 | Interrupt, pending gated by enable |

## Verification
The counter is driven up to each carry boundary in turn: the second and minute wrap, the hour wrap with weekday roll, 30- and 31-day month ends, February in both leap and common years (including year 00 and an odd-tens leap year), and the year-99 century carry. These cases separate a missing carry from a wrong month length and a wrong leap rule. The alarm is tried in four ways: with no field enabled while the time passes through a matching value, with a single enabled field next to a disabled field that mismatches, with two enabled fields where one mismatches, and with an hour compare whose 24-hour mode bit differs from the enable. These cases separate field selection from full-byte comparison. Writes that coincide with a tick, and a status clear that coincides with a match, test the ordering rules.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned FIELDS     = 8;
  localparam int unsigned CMP_FIELDS = 5;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_DATE = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YEAR = 5;
  localparam int unsigned F_WDAY = 6;
  localparam int unsigned F_CENT = 7;

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4 in BCD: even tens with 0/4/8, odd tens with 2/6
  function automatic logic bcd_leap(input byte_t y);
    logic u048, u26;
    u048 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    u26  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? u26 : u048;
  endfunction

  function automatic byte_t bcd_month_len(input byte_t m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic byte_t field_reset(input int unsigned f);
    case (f)
      F_HOUR:        return 8'h80;
      F_DATE, F_MON: return 8'h01;
      F_CENT:        return 8'h20;
      default:       return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_timekeeper.sv
module bcd_rtc_timekeeper
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned NF = FIELDS,
  parameter int unsigned NC = CMP_FIELDS,
  localparam int unsigned SW = $clog2(NF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_i,
  input  logic [SW-1:0]        wsel_i,
  input  byte_t                wdata_i,
  output logic [NF-1:0][7:0]   time_o,
  output logic [NC-1:0][7:0]   next_o
);
  logic [NF-1:0][7:0] cur_q, nxt;
  logic  c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  byte_t mlen;
  logic [5:0] hr;

  always_comb begin
    nxt   = cur_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0;
    c_mon = 1'b0; c_yr = 1'b0; c_cen = 1'b0;
    hr    = cur_q[F_HOUR][5:0];
    mlen  = bcd_month_len(cur_q[F_MON], bcd_leap(cur_q[F_YEAR]));
    if (tick_i) begin
      if (cur_q[F_SEC] >= 8'h59) begin nxt[F_SEC] = 8'h00; c_min = 1'b1; end
      else nxt[F_SEC] = bcd_inc(cur_q[F_SEC]);
      if (c_min) begin
        if (cur_q[F_MIN] >= 8'h59) begin nxt[F_MIN] = 8'h00; c_hr = 1'b1; end
        else nxt[F_MIN] = bcd_inc(cur_q[F_MIN]);
      end
      if (c_hr) begin
        if (hr >= 6'h23) begin
          nxt[F_HOUR] = {cur_q[F_HOUR][7:6], 6'h00};
          c_day = 1'b1;
        end else if (hr[3:0] >= 4'd9) begin
          nxt[F_HOUR] = {cur_q[F_HOUR][7:6], hr[5:4] + 2'd1, 4'd0};
        end else begin
          nxt[F_HOUR] = {cur_q[F_HOUR][7:6], hr[5:4], hr[3:0] + 4'd1};
        end
      end
      if (c_day) begin
        nxt[F_WDAY] = (cur_q[F_WDAY][2:0] >= 3'd6) ? 8'h00
                      : {5'd0, cur_q[F_WDAY][2:0] + 3'd1};
        if (cur_q[F_DATE] >= mlen) begin nxt[F_DATE] = 8'h01; c_mon = 1'b1; end
        else nxt[F_DATE] = bcd_inc(cur_q[F_DATE]);
      end
      if (c_mon) begin
        if (cur_q[F_MON] >= 8'h12) begin nxt[F_MON] = 8'h01; c_yr = 1'b1; end
        else nxt[F_MON] = bcd_inc(cur_q[F_MON]);
      end
      if (c_yr) begin
        if (cur_q[F_YEAR] >= 8'h99) begin nxt[F_YEAR] = 8'h00; c_cen = 1'b1; end
        else nxt[F_YEAR] = bcd_inc(cur_q[F_YEAR]);
      end
      if (c_cen) nxt[F_CENT] = bcd_inc(cur_q[F_CENT]);
    end
    // write lands after the advance
    if (wr_i)
      nxt[wsel_i] = (wsel_i == SW'(F_WDAY)) ? (wdata_i & 8'h07) : wdata_i;
  end

  for (genvar f = 0; f < NF; f++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cur_q[f] <= field_reset(f);
      else         cur_q[f] <= nxt[f];
    end
  end

  assign time_o = cur_q;
  assign next_o = nxt[NC-1:0];
endmodule

// File: rtl/bcd_rtc_alarm_match.sv
module bcd_rtc_alarm_match
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned NF = FIELDS,
  parameter int unsigned NC = CMP_FIELDS,
  localparam int unsigned SW = $clog2(NF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_i,
  input  logic [SW-1:0]        wsel_i,
  input  byte_t                wdata_i,
  input  logic [NC-1:0][7:0]   now_i,
  output logic [NF-1:0][7:0]   alarm_o,
  output logic                 hit_o
);
  logic [NF-1:0][7:0] alm_q;
  logic [NC-1:0]      en, eq;

  for (genvar f = 0; f < NF; f++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          alm_q[f] <= 8'h00;
      else if (wr_i && wsel_i == SW'(f))    alm_q[f] <= wdata_i;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cmp
    localparam byte_t MASK = (c == F_HOUR) ? 8'h3F : 8'h7F;
    assign en[c] = alm_q[c][7];
    assign eq[c] = ((alm_q[c] ^ now_i[c]) & MASK) == 8'h00;
  end

  assign hit_o   = tick_i & (|en) & (&(eq | ~en));
  assign alarm_o = alm_q;
endmodule

// File: rtl/bcd_rtc_flags.sv
module bcd_rtc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic st_wr_i,
  input  logic ctl_wr_i,
  input  logic wbit_i,
  output logic pending_o,
  output logic irq_en_o,
  output logic irq_o
);
  logic pend_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (hit_i)              pend_q <= 1'b1;
    else if (st_wr_i && !wbit_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (ctl_wr_i) en_q <= wbit_i;
  end

  assign pending_o = pend_q;
  assign irq_en_o  = en_q;
  assign irq_o     = pend_q & en_q;
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 6,
  parameter logic [ADDR_W-1:0]  TIME_BASE = 6'h30,
  parameter logic [ADDR_W-1:0]  ALM_BASE  = 6'h00,
  parameter logic [ADDR_W-1:0]  CTL_ADDR  = 6'h11,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = 6'h3F,
  parameter int unsigned        FLAG_BIT  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              alarm_pending_o,
  output logic              irq_o
);
  localparam int unsigned SW = $clog2(FIELDS);

  logic [FIELDS-1:0][7:0]     time_q, alarm_q;
  logic [CMP_FIELDS-1:0][7:0] time_next;
  logic [SW-1:0]              sel;
  logic time_sel, alm_sel, ctl_sel, stat_sel;
  logic hit, pending, irq_en;

  assign sel      = addr_i[SW-1:0];
  assign time_sel = addr_i[ADDR_W-1:SW] == TIME_BASE[ADDR_W-1:SW];
  assign alm_sel  = addr_i[ADDR_W-1:SW] == ALM_BASE[ADDR_W-1:SW];
  assign ctl_sel  = addr_i == CTL_ADDR;
  assign stat_sel = addr_i == STAT_ADDR;

  bcd_rtc_timekeeper #(.NF(FIELDS), .NC(CMP_FIELDS)) u_time (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_i   (wr_i & time_sel),
    .wsel_i (sel),
    .wdata_i(wdata_i),
    .time_o (time_q),
    .next_o (time_next)
  );

  bcd_rtc_alarm_match #(.NF(FIELDS), .NC(CMP_FIELDS)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_i   (wr_i & alm_sel),
    .wsel_i (sel),
    .wdata_i(wdata_i),
    .now_i  (time_next),
    .alarm_o(alarm_q),
    .hit_o  (hit)
  );

  bcd_rtc_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .st_wr_i  (wr_i & stat_sel),
    .ctl_wr_i (wr_i & ctl_sel),
    .wbit_i   (wdata_i[FLAG_BIT]),
    .pending_o(pending),
    .irq_en_o (irq_en),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (time_sel)      rdata_o = time_q[sel];
    else if (alm_sel)  rdata_o = alarm_q[sel];
    else if (ctl_sel)  rdata_o[FLAG_BIT] = irq_en;
    else if (stat_sel) rdata_o[FLAG_BIT] = pending;
  end

  assign alarm_pending_o = pending;
endmodule

// File: rtl/bcd_rtc_alarm_chk.sv
module bcd_rtc_alarm_chk #(
  parameter int unsigned       ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h3F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              stat_bit_i,
  input logic              alarm_pending_o,
  input logic              irq_o,
  input logic [7:0][7:0]   time_q
);
  assert_sec_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && time_q[0] == 8'h59) |=> (time_q[0] == 8'h00));

  assert_pend_from_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_pending_o) |-> $past(tick_i));

  assert_pend_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == STAT_ADDR && !stat_bit_i && !tick_i) |=> !alarm_pending_o);

  assert_irq_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> alarm_pending_o);

  assert_time_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(time_q));
endmodule

bind bcd_rtc_alarm bcd_rtc_alarm_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .wr_i           (wr_i),
  .addr_i         (addr_i),
  .stat_bit_i     (wdata_i[FLAG_BIT]),
  .alarm_pending_o(alarm_pending_o),
  .irq_o          (irq_o),
  .time_q         (time_q)
);

// File: tb/bcd_rtc_alarm_tb.sv
module bcd_rtc_alarm_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       alarm_pending_o, irq_o;

  always #5 clk_i = ~clk_i;

  bcd_rtc_alarm u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .alarm_pending_o(alarm_pending_o), .irq_o(irq_o)
  );

  typedef struct {
    int         kind;   // 0 register, 1 pending, 2 irq
    logic [5:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  smp_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // monitor
  initial forever begin
    item_t it;
    logic [7:0] got;
    @(smp_ev);
    #1;
    it = q.pop_front();
    case (it.kind)
      1:       got = {7'd0, alarm_pending_o};
      2:       got = {7'd0, irq_o};
      default: got = rdata_o;
    endcase
    checks++;
    if (got !== it.exp) begin
      errors++;
      $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h", it.tag, it.kind, it.a, got, it.exp);
    end
  end

  task automatic exp_reg(input logic [5:0] a, input logic [7:0] e, input string tag);
    q.push_back('{0, a, e, tag});
    addr_i = a;
    ->smp_ev;
    #2;
  endtask

  task automatic exp_flag(input int k, input logic e, input string tag);
    q.push_back('{k, 6'h00, {7'd0, e}, tag});
    ->smp_ev;
    #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic wr_tick(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; tick_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, w, c);
    wr(6'h30, s); wr(6'h31, mi); wr(6'h32, h); wr(6'h33, d);
    wr(6'h34, mo); wr(6'h35, y); wr(6'h36, w); wr(6'h37, c);
  endtask

  task automatic day_end(input logic [7:0] d, mo, y);
    wr(6'h30, 8'h59); wr(6'h31, 8'h59); wr(6'h32, 8'h23);
    wr(6'h33, d); wr(6'h34, mo); wr(6'h35, y);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    exp_reg(6'h30, 8'h00, "R1 sec");
    exp_reg(6'h32, 8'h80, "R1 hour");
    exp_reg(6'h33, 8'h01, "R1 date");
    exp_reg(6'h34, 8'h01, "R1 month");
    exp_reg(6'h37, 8'h20, "R1 century");
    exp_reg(6'h00, 8'h00, "R1 alarm sec");
    exp_flag(1, 1'b0, "R1 pending");
    exp_flag(2, 1'b0, "R1 irq");

    // R3 second and minute carry
    set_time(8'h58, 8'h07, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
    tick();
    exp_reg(6'h30, 8'h59, "R3 sec inc");
    tick();
    exp_reg(6'h30, 8'h00, "R3 sec wrap");
    exp_reg(6'h31, 8'h08, "R3 min carry");
    exp_reg(6'h32, 8'h80, "R4 mode bit kept");
    wr(6'h30, 8'h59); wr(6'h31, 8'h59); wr(6'h32, 8'h85);
    tick();
    exp_reg(6'h31, 8'h00, "R3 min wrap");
    exp_reg(6'h32, 8'h86, "R3 hour carry");

    // R4 hour wrap into date and weekday
    set_time(8'h59, 8'h59, 8'h23, 8'h10, 8'h05, 8'h21, 8'h06, 8'h20);
    tick();
    exp_reg(6'h32, 8'h00, "R4 hour wrap");
    exp_reg(6'h33, 8'h11, "R4 date inc");
    exp_reg(6'h36, 8'h00, "R4 weekday wrap");

    // R5 month lengths
    day_end(8'h30, 8'h04, 8'h21); tick();
    exp_reg(6'h33, 8'h01, "R5 april end date");
    exp_reg(6'h34, 8'h05, "R5 april end month");
    day_end(8'h30, 8'h01, 8'h21); tick();
    exp_reg(6'h33, 8'h31, "R5 january 31");
    exp_reg(6'h34, 8'h01, "R5 january holds");

    // R6 february
    day_end(8'h28, 8'h02, 8'h23); tick();
    exp_reg(6'h33, 8'h01, "R6 common year date");
    exp_reg(6'h34, 8'h03, "R6 common year month");
    day_end(8'h28, 8'h02, 8'h24); tick();
    exp_reg(6'h33, 8'h29, "R6 leap 24 day 29");
    day_end(8'h29, 8'h02, 8'h24); tick();
    exp_reg(6'h33, 8'h01, "R6 leap 24 end");
    exp_reg(6'h34, 8'h03, "R6 leap 24 month");
    day_end(8'h28, 8'h02, 8'h00); tick();
    exp_reg(6'h33, 8'h29, "R6 leap 00");
    day_end(8'h28, 8'h02, 8'h12); tick();
    exp_reg(6'h33, 8'h29, "R6 leap 12");

    // R7 year and century
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h02, 8'h20);
    tick();
    exp_reg(6'h34, 8'h01, "R7 month wrap");
    exp_reg(6'h35, 8'h00, "R7 year wrap");
    exp_reg(6'h37, 8'h21, "R7 century inc");
    exp_reg(6'h36, 8'h03, "R4 weekday inc");

    // R8 write with tick
    wr(6'h30, 8'h10); wr(6'h31, 8'h05);
    wr_tick(6'h31, 8'h42);
    exp_reg(6'h30, 8'h11, "R8 tick applied");
    exp_reg(6'h31, 8'h42, "R8 write wins field");

    // R2 map details
    wr(6'h36, 8'hFF);
    exp_reg(6'h36, 8'h07, "R2 weekday mask");
    exp_reg(6'h20, 8'h00, "R2 unmapped");
    exp_reg(6'h11, 8'h00, "R2 ctrl reset");

    // R13 hold
    exp_reg(6'h30, 8'h11, "R13 before idle");
    repeat (5) @(negedge clk_i);
    exp_reg(6'h30, 8'h11, "R13 after idle");

    // R10 no enabled field: time passed sec 00 many times
    exp_flag(1, 1'b0, "R10 no enables no match");

    // R9/R10 single field, disabled field mismatched
    wr(6'h00, 8'h85); wr(6'h01, 8'h30);
    exp_reg(6'h00, 8'h85, "R2 alarm readback");
    wr(6'h30, 8'h03); wr(6'h31, 8'h07);
    tick();
    exp_flag(1, 1'b0, "R9 no match yet");
    tick();
    exp_flag(1, 1'b1, "R10 disabled min ignored");
    exp_flag(2, 1'b0, "R12 irq masked");
    exp_reg(6'h3F, 8'h20, "R2 status bit");
    wr(6'h11, 8'h20);
    exp_reg(6'h11, 8'h20, "R2 ctrl bit");
    exp_flag(2, 1'b1, "R12 irq enabled");
    tick();
    exp_flag(1, 1'b1, "R11 sticky after tick");
    wr(6'h3F, 8'h20);
    exp_flag(1, 1'b1, "R11 write one keeps");
    wr(6'h3F, 8'hDF);
    exp_flag(1, 1'b0, "R11 write zero clears");
    exp_flag(2, 1'b0, "R12 irq follows clear");

    // R9 two enabled fields, one mismatched
    wr(6'h01, 8'h89);
    wr(6'h30, 8'h04);
    tick();
    exp_flag(1, 1'b0, "R9 enabled min mismatch");
    wr(6'h30, 8'h04); wr(6'h31, 8'h09);
    tick();
    exp_flag(1, 1'b1, "R9 two field match");
    wr(6'h3F, 8'h00);

    // R9 hour compares low 6 bits despite mode bit
    wr(6'h02, 8'h92);
    wr(6'h30, 8'h04); wr(6'h31, 8'h09); wr(6'h32, 8'h12);
    tick();
    exp_flag(1, 1'b1, "R9 hour match ignores bit7");
    wr(6'h3F, 8'h00);

    // R11 clear in same cycle as match
    wr(6'h30, 8'h04);
    wr_tick(6'h3F, 8'h00);
    exp_flag(1, 1'b1, "R11 match beats clear");

    #20;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule